// File: doc/BRIEF.md
# Pixel Format Unpacker with Colour Palette

This block sits in a display scan-out path and turns one stored pixel word into four 8-bit channels: red, green, blue and alpha. A 3-bit format code arrives with each pixel. It selects one of five formats: 8-bit palette-indexed, 16-bit 5-6-5, 16-bit 1-5-5-5, 24-bit packed, or 32-bit with alpha. For indexed pixels, the low byte of the word addresses a 32-bit palette RAM. For direct-colour formats, the colour fields are extracted from the word and widened to 8 bits.

The host loads the palette through a small write port with an index, a data word and a write strobe. The pixel stream has no back-pressure. Every accepted pixel appears on the outputs exactly two clock edges later, whatever its format. This keeps the palette read and the direct-colour path aligned.

The datapath has two register stages. In stage one, the pixel, its format and the palette read data are captured. In stage two, the decoded colour and the output valid are registered. The decode is a single `unique case` over the enumerated format code. Every code value, including the three unused ones, has its own branch.

Top module: `pix_unpack_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first pixel is accepted, `out_valid` is 0 and all four colour outputs are 0.
- R2: A pixel accepted with `in_valid`=1 at a rising edge appears with `out_valid`=1 after the second following rising edge. `out_valid` is 0 in every cycle that matches no accepted pixel. Back-to-back pixels of mixed formats stay in order.
- R3: Code 1 (5-6-5) takes blue from bits [4:0], green from [10:5] and red from [15:11]. A 5-bit field f widens to {f, f[4:2]` and a 6-bit field g widens to {g, g[5:4]}. Alpha is 0xFF.
- R4: Code 2 (1-5-5-5) takes blue from [4:0], green from [9:5] and red from [14:10], each widened as in R3. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R5: Code 4 (24-bit) outputs blue=[7:0], green=[15:8], red=[23:16] and alpha=0xFF. Bits [31:24] have no effect.
- R6: Code 5 (32-bit) outputs blue=[7:0], green=[15:8], red=[23:16] and alpha=[31:24].
- R7: Codes 3, 6 and 7 output 0 on all four channels, whatever the pixel word holds.
- R8: Code 0 uses pixel bits [7:0] as the palette index. Bits [31:8] have no effect. The palette entry maps alpha=[31:24], red=[23:16], green=[15:8] and blue=[7:0].
- R9: A host write with `host_we`=1 stores `host_wdata` at `host_idx` when the index is below 1024. A write to an index of 1024 or more changes no entry. In particular, it does not alias onto its low 10 bits.
- R10: When a host write and an indexed lookup hit the same entry in the same cycle, the lookup returns the entry's previous contents. A lookup in the next cycle returns the new contents.
- R11: For codes 1 and 2, pixel bits [31:16] have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| in_valid | input | 1 | Pixel present this cycle |
| in_fmt | input | 3 | Format code of the pixel |
| in_pix | input | 32 | Stored pixel word |
| host_we | input | 1 | Palette write strobe |
| host_idx | input | 16 | Palette write index |
| host_wdata | input | 32 | Palette entry to write |
| out_valid | output | 1 | Decoded pixel present |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |
| out_a | output | 8 | Alpha channel |

## Verification
Each decoded colour is due exactly two rising edges after the edge that accepted its pixel. A palette write is visible to an indexed lookup accepted one edge after the write edge, but not to a lookup accepted on the same edge. The driver records the cycle number at which each expected colour must appear. The monitor samples on the falling edge and compares the arrival cycle as well as the value. An early, late or unexpected `out_valid` therefore fails, as does a wrong colour. The ignored-write cases are observed through later lookups of the entry that a wrongly aliased write would have overwritten.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    localparam int PIX_W = 32;
    localparam int CH_W  = 8;

    typedef enum logic [2:0] {
        FMT_IDX8     = 3'd0,
        FMT_RGB565   = 3'd1,
        FMT_ARGB1555 = 3'd2,
        FMT_RSVD3    = 3'd3,
        FMT_RGB888   = 3'd4,
        FMT_ARGB8888 = 3'd5,
        FMT_RSVD6    = 3'd6,
        FMT_RSVD7    = 3'd7
    } pix_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgba_t;

    // Widen a 5-bit channel by repeating its top bits underneath.
    function automatic logic [CH_W-1:0] widen5(input logic [4:0] f);
        return {f, f[4:2]};
    endfunction

    // Widen a 6-bit channel by repeating its top bits underneath.
    function automatic logic [CH_W-1:0] widen6(input logic [5:0] f);
        return {f, f[5:4]};
    endfunction

endpackage

// File: rtl/pix_palette.sv
module pix_palette #(
    parameter int DEPTH    = 1024,
    parameter int DATA_W   = 32,
    parameter int WADDR_W  = 16,
    parameter int RADDR_W  = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               re,
    input  logic [RADDR_W-1:0] raddr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [WADDR_W:0] LIMIT = (WADDR_W+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_in_range;
    logic [IDX_W-1:0]  rd_idx;

    // Writes outside the table are dropped rather than folded onto low bits.
    assign wr_in_range = ({1'b0, waddr} < LIMIT);
    assign rd_idx      = IDX_W'(raddr);

    // Read and write share one process: a same-cycle hit returns old data.
    always_ff @(posedge clk) begin
        if (we && wr_in_range) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
        if (re) begin
            rdata <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/pix_color_decode.sv
module pix_color_decode
    import pix_unpack_pkg::*;
(
    input  pix_fmt_e             fmt,
    input  logic [PIX_W-1:0]     pix,
    input  logic [PIX_W-1:0]     pal_entry,
    output rgba_t                color
);
    always_comb begin
        color = '0;
        unique case (fmt)
            FMT_IDX8: begin
                color = rgba_t'(pal_entry);
            end
            FMT_RGB565: begin
                color.a = 8'hFF;
                color.r = widen5(pix[15:11]);
                color.g = widen6(pix[10:5]);
                color.b = widen5(pix[4:0]);
            end
            FMT_ARGB1555: begin
                color.a = {CH_W{pix[15]}};
                color.r = widen5(pix[14:10]);
                color.g = widen5(pix[9:5]);
                color.b = widen5(pix[4:0]);
            end
            FMT_RGB888: begin
                color.a = 8'hFF;
                color.r = pix[23:16];
                color.g = pix[15:8];
                color.b = pix[7:0];
            end
            FMT_ARGB8888: begin
                color = rgba_t'(pix);
            end
            FMT_RSVD3, FMT_RSVD6, FMT_RSVD7: begin
                color = '0;
            end
        endcase
    end

endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
    import pix_unpack_pkg::*;
#(
    parameter int PAL_DEPTH   = 1024,
    parameter int HOST_ADDR_W = 16,
    parameter int LOOKUP_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             in_fmt,
    input  logic [PIX_W-1:0]       in_pix,
    input  logic                   host_we,
    input  logic [HOST_ADDR_W-1:0] host_idx,
    input  logic [PIX_W-1:0]       host_wdata,
    output logic                   out_valid,
    output logic [CH_W-1:0]        out_r,
    output logic [CH_W-1:0]        out_g,
    output logic [CH_W-1:0]        out_b,
    output logic [CH_W-1:0]        out_a
);
    // Stage one: pixel, format and palette read captured together.
    logic             s1_valid;
    pix_fmt_e         s1_fmt;
    logic [PIX_W-1:0] s1_pix;
    logic [PIX_W-1:0] s1_pal;

    // Stage two: decoded colour.
    rgba_t            dec_color;
    rgba_t            s2_color;
    logic             s2_valid;

    pix_palette #(
        .DEPTH   (PAL_DEPTH),
        .DATA_W  (PIX_W),
        .WADDR_W (HOST_ADDR_W),
        .RADDR_W (LOOKUP_W)
    ) i_palette (
        .clk   (clk),
        .we    (host_we),
        .waddr (host_idx),
        .wdata (host_wdata),
        .re    (in_valid),
        .raddr (in_pix[LOOKUP_W-1:0]),
        .rdata (s1_pal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_fmt   <= FMT_IDX8;
            s1_pix   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_fmt <= pix_fmt_e'(in_fmt);
                s1_pix <= in_pix;
            end
        end
    end

    pix_color_decode i_decode (
        .fmt       (s1_fmt),
        .pix       (s1_pix),
        .pal_entry (s1_pal),
        .color     (dec_color)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_color <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_color <= dec_color;
            end
        end
    end

    assign out_valid = s2_valid;
    assign out_r     = s2_color.r;
    assign out_g     = s2_color.g;
    assign out_b     = s2_color.b;
    assign out_a     = s2_color.a;

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  in_fmt,
    input logic [31:0] in_pix,
    input logic        out_valid,
    input logic [7:0]  out_r,
    input logic [7:0]  out_g,
    input logic [7:0]  out_b,
    input logic [7:0]  out_a
);
    logic [1:0]  vq;
    logic [2:0]  fq0, fq1;
    logic [31:0] pq0, pq1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vq  <= '0;
            fq0 <= '0;
            fq1 <= '0;
            pq0 <= '0;
            pq1 <= '0;
        end else begin
            vq  <= {vq[0], in_valid};
            fq0 <= in_fmt;
            fq1 <= fq0;
            pq0 <= in_pix;
            pq1 <= pq0;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[1]); // R2

    AST_565_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fq1 == 3'd1) |-> (out_r[7:3] == pq1[15:11] && out_g[7:2] == pq1[10:5]
                                        && out_b[7:3] == pq1[4:0] && out_a == 8'hFF)); // R3

    AST_1555_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fq1 == 3'd2) |-> (out_a == {8{pq1[15]}})); // R4

    AST_888_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fq1 == 3'd4) |-> (out_a == 8'hFF && {out_r, out_g, out_b} == pq1[23:0])); // R5

    AST_8888_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fq1 == 3'd5) |-> ({out_a, out_r, out_g, out_b} == pq1)); // R6

    AST_UNUSED_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (fq1 == 3'd3 || fq1 == 3'd6 || fq1 == 3'd7))
            |-> ({out_a, out_r, out_g, out_b} == 32'h0)); // R7

endmodule

bind pix_unpack_top pix_unpack_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_fmt    (in_fmt),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b),
    .out_a     (out_a)
);

// File: tb/test_pix_unpack_top.sv
module test_pix_unpack_top;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_fmt;
    logic [31:0] in_pix;
    logic        host_we;
    logic [15:0] host_idx;
    logic [31:0] host_wdata;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b, out_a;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    int          due_q[$];
    logic [31:0] exp_q[$];
    string       req_q[$];

    logic [31:0] pal_m [1024];

    pix_unpack_top i_pix_unpack_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_fmt     (in_fmt),
        .in_pix     (in_pix),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .out_valid  (out_valid),
        .out_r      (out_r),
        .out_g      (out_g),
        .out_b      (out_b),
        .out_a      (out_a)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model_color(logic [2:0] f, logic [31:0] p);
        int r, g, b, a;
        case (f)
            3'd0: return pal_m[int'(p[7:0])];
            3'd1: begin
                r = int'(p[15:11]); r = (r << 3) | (r >> 2);
                g = int'(p[10:5]);  g = (g << 2) | (g >> 4);
                b = int'(p[4:0]);   b = (b << 3) | (b >> 2);
                a = 255;
            end
            3'd2: begin
                r = int'(p[14:10]); r = (r << 3) | (r >> 2);
                g = int'(p[9:5]);   g = (g << 3) | (g >> 2);
                b = int'(p[4:0]);   b = (b << 3) | (b >> 2);
                a = p[15] ? 255 : 0;
            end
            3'd4: begin
                r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]); a = 255;
            end
            3'd5: return p;
            default: return 32'h0;
        endcase
        return {a[7:0], r[7:0], g[7:0], b[7:0]};
    endfunction

    // Driver: one cycle of stimulus, expected item queued with its due cycle.
    task automatic step(bit v, logic [2:0] f, logic [31:0] p,
                        bit we, logic [15:0] wi, logic [31:0] wd, string req);
        in_valid   = v;
        in_fmt     = f;
        in_pix     = p;
        host_we    = we;
        host_idx   = wi;
        host_wdata = wd;
        if (v) begin
            due_q.push_back(cyc + 2);
            exp_q.push_back(model_color(f, p));
            req_q.push_back(req);
        end
        if (we && wi < 16'd1024) pal_m[int'(wi)] = wd;
        @(negedge clk);
    endtask

    task automatic pix(logic [2:0] f, logic [31:0] p, string req);
        step(1'b1, f, p, 1'b0, 16'd0, 32'd0, req);
    endtask

    task automatic wr(logic [15:0] wi, logic [31:0] wd);
        step(1'b0, 3'd0, 32'd0, 1'b1, wi, wd, "");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 1'b0, 16'd0, 32'd0, "");
    endtask

    // Monitor: compares value and arrival cycle of every result.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                checks++;
                if (due_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected out_valid at cycle %0d: actual 1 expected 0", cyc);
                end else begin
                    automatic int          d = due_q.pop_front();
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string       q = req_q.pop_front();
                    automatic logic [31:0] act = {out_a, out_r, out_g, out_b};
                    if (d != cyc) begin
                        errors++;
                        $display("FAIL R2 (%s) arrival cycle actual %0d expected %0d", q, cyc, d);
                    end else if (act !== e) begin
                        errors++;
                        $display("FAIL %s colour actual %h expected %h", q, act, e);
                    end
                end
            end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
                checks++;
                errors++;
                $display("FAIL R2 (%s) missing result due at cycle %0d, actual none", req_q[0], due_q[0]);
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired: actual hung expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_fmt = 3'd0; in_pix = '0;
        host_we = 1'b0; host_idx = '0; host_wdata = '0;
        for (int i = 0; i < 1024; i++) pal_m[i] = 32'h0;
        repeat (4) @(negedge clk);
        checks++;
        if ({out_valid, out_a, out_r, out_g, out_b} !== 33'h0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %h expected 0", {out_valid, out_a, out_r, out_g, out_b});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({out_valid, out_a, out_r, out_g, out_b} !== 33'h0) begin
            errors++;
            $display("FAIL R1 post-reset outputs actual %h expected 0", {out_valid, out_a, out_r, out_g, out_b});
        end

        // R9: palette loads
        wr(16'd5,   32'h80112233);
        wr(16'd255, 32'h11AABBCC);
        wr(16'd0,   32'hFF000000);
        wr(16'd7,   32'h01020304);
        // R8: lookups, upper bits ignored
        pix(3'd0, 32'h00000005, "R8");
        pix(3'd0, 32'hABCDEF05, "R8");
        pix(3'd0, 32'h000000FF, "R8");
        pix(3'd0, 32'h12345600, "R8");
        // R9: out-of-range writes alias-free
        wr(16'd1029,  32'hDEADBEEF);
        wr(16'hFFFF,  32'hCAFEF00D);
        wr(16'd1024,  32'h55555555);
        pix(3'd0, 32'h00000005, "R9");
        pix(3'd0, 32'h00000000, "R9");
        // R10: same-cycle write and lookup returns old, then new
        step(1'b1, 3'd0, 32'h00000007, 1'b1, 16'd7, 32'h0A0B0C0D, "R10");
        pix(3'd0, 32'h00000007, "R10");
        idle(3);
        // R3 / R11: 5-6-5
        pix(3'd1, 32'h0000FFFF, "R3");
        pix(3'd1, 32'h00000000, "R3");
        pix(3'd1, 32'h0000F800, "R3");
        pix(3'd1, 32'h000007E0, "R3");
        pix(3'd1, 32'h0000001F, "R3");
        pix(3'd1, 32'hABCD8410, "R11");
        // R4 / R11: 1-5-5-5
        pix(3'd2, 32'h00008000, "R4");
        pix(3'd2, 32'h00007FFF, "R4");
        pix(3'd2, 32'h00007C00, "R4");
        pix(3'd2, 32'h55551234, "R11");
        // R5, R6
        pix(3'd4, 32'h12345678, "R5");
        pix(3'd4, 32'hFF000000, "R5");
        pix(3'd5, 32'h12345678, "R6");
        pix(3'd5, 32'h00FFFFFF, "R6");
        // R7: unused codes
        pix(3'd3, 32'hFFFFFFFF, "R7");
        pix(3'd6, 32'hFFFFFFFF, "R7");
        pix(3'd7, 32'h89ABCDEF, "R7");
        // R2: mixed stream with gaps
        pix(3'd5, 32'hA1B2C3D4, "R2");
        pix(3'd0, 32'h000000FF, "R2");
        idle(1);
        pix(3'd1, 32'h00001234, "R2");
        idle(2);
        pix(3'd4, 32'h00ABCDEF, "R2");
        pix(3'd2, 32'h0000FC1F, "R2");
        idle(5);
        checks++;
        if (due_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending results actual %0d expected 0", due_q.size());
        end
        finish_run();
    end

endmodule